// File: doc/BRIEF.md
# Link Power-State Monitor and Interface Gate

This block sits between a physical-layer core and the pins that face a link-layer controller. The link controller reports whether it is powered through a single status input. The block measures how long that input stays low and changes the state of the interface to match. A low of moderate length resets the interface. The control and data lines toward the link are forced low, but the interface clock keeps running. A low that lasts much longer disables the interface. The lines stay low and the interface clock is also gated off.

When the status input goes high again, the block does not release the interface at once. It waits for a restore interval, with the clock running and the lines still forced low, and then passes the core's control and data values through unchanged. All timing runs on a free-running reference clock that is never gated. The reset, disable and restore thresholds are parameters given in reference-clock cycles. With the default 125 MHz reference they are about 2 µs, 27 µs and 17 µs.

The status input passes through a synchronizer before any timing is measured. The clock-enable output drives an external clock gate. The reset-active, disabled and link-up flags come from registers, so each one changes only on a reference-clock edge.

Top module: `link_pwr_gate`

## Requirements
- R1: While the synchronous reset `rst` is high, and after it is released while `lps_i` stays low, the block is in the disabled state. In that state `dis_o`=1, `rst_act_o`=0, `up_o`=0, `clk_en_o`=0, and `ctl_o` and `data_o` are all zero.
- R2: In the enabled state (`up_o`=1), `ctl_o` equals `ctl_i` and `data_o` equals `data_i` bit for bit, and `clk_en_o`=1.
- R3: A synchronized low on `lps_i` lasting `RST_CYC` reference cycles moves the block from enabled to reset. In reset, `rst_act_o`=1, `up_o`=0, `clk_en_o`=1, and `ctl_o` and `data_o` are zero. A low shorter than `RST_CYC` minus the synchronizer latency leaves the block enabled.
- R4: A high on `lps_i` long enough to pass the synchronizer restarts the low-duration measurement. Two lows, each shorter than `RST_CYC`, separated by such a high, do not cause a reset.
- R5: A low lasting `DIS_CYC` cycles from its falling edge moves the block from reset to disabled, with `dis_o`=1, `rst_act_o`=0 and `clk_en_o`=0. The disabled state is only entered from the reset state, so a low always passes through reset first.
- R6: When `lps_i` returns high from reset or disabled, the block restores. During restore, `up_o`=0, `rst_act_o`=0, `dis_o`=0, `clk_en_o`=1 and the outputs are forced to zero. After `RES_CYC` cycles of continuous high, the block returns to enabled.
- R7: A low on `lps_i` during restore sends the block back to the reset state (`rst_act_o`=1, `clk_en_o`=1) at once. The disable threshold is then timed from this new falling edge.
- R8: At most one of `rst_act_o`, `dis_o` and `up_o` is high in any cycle, and `clk_en_o` is low exactly when `dis_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| rst | input | 1 | Synchronous reset, active high |
| lps_i | input | 1 | Link power-status input (asynchronous) |
| ctl_i | input | 2 | Control values from the physical-layer core |
| data_i | input | 8 | Data values from the physical-layer core |
| ctl_o | output | 2 | Control lines toward the link, gated |
| data_o | output | 8 | Data lines toward the link, gated |
| clk_en_o | output | 1 | Enable for the external interface-clock gate |
| rst_act_o | output | 1 | Interface is held in reset |
| dis_o | output | 1 | Interface is disabled |
| up_o | output | 1 | Interface is enabled and passing data |

## Verification
The hardest situation to reach is a restore that is cut short. The block has to pass through reset, then disable or reset again, then a partial high period, and then fall low again before the restore count completes. The stimulus first drives a reset-length low, then a high of half the restore interval, then a new low. After that new low it checks that reset is re-entered quickly. It then checks that the disable threshold is timed from the new falling edge and not from the first low. The bench also pairs windows just short of each threshold with windows just past it, so that an off-by-margin counter shows up on one side.

// File: rtl/lpg_pkg.sv
package lpg_pkg;
   typedef enum logic [1:0] {
      ST_EN  = 2'd0,
      ST_RST = 2'd1,
      ST_DIS = 2'd2,
      ST_RES = 2'd3
   } lpg_state_t;
endpackage

// File: rtl/lpg_sync.sv
module lpg_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] chain;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk) begin
            if (rst) chain[i] <= 1'b0;
            else     chain[i] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk) begin
            if (rst) chain[i] <= 1'b0;
            else     chain[i] <= chain[i-1];
         end
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/lpg_timer.sv
module lpg_timer #(
   parameter int MAX_CYC = 4000,
   localparam int CNT_W  = $clog2(MAX_CYC + 1)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             lvl_i,
   output logic             lvl_o,
   output logic [CNT_W-1:0] cnt_o
);
   localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(MAX_CYC);

   logic chg;
   assign chg = (lvl_i != lvl_o);

   always_ff @(posedge clk) begin
      if (rst) begin
         lvl_o <= 1'b0;
         cnt_o <= '0;
      end else begin
         lvl_o <= lvl_i;
         if (chg)                  cnt_o <= '0;
         else if (cnt_o != CNT_TOP) cnt_o <= cnt_o + 1'b1;
      end
   end
endmodule

// File: rtl/lpg_fsm.sv
module lpg_fsm
   import lpg_pkg::*;
#(
   parameter int RST_CYC = 250,
   parameter int DIS_CYC = 3375,
   parameter int RES_CYC = 2125,
   parameter int CNT_W   = 12
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             lvl_i,
   input  logic [CNT_W-1:0] cnt_i,
   output logic             clk_en_o,
   output logic             rst_act_o,
   output logic             dis_o,
   output logic             up_o
);
   localparam logic [CNT_W-1:0] RST_LIM = CNT_W'(RST_CYC - 1);
   localparam logic [CNT_W-1:0] DIS_LIM = CNT_W'(DIS_CYC - 1);
   localparam logic [CNT_W-1:0] RES_LIM = CNT_W'(RES_CYC - 1);

   lpg_state_t st, nxt;

   always_comb begin
      nxt = st;
      unique case (st)
         ST_EN:  if (!lvl_i && cnt_i >= RST_LIM) nxt = ST_RST;
         ST_RST: if (lvl_i) nxt = ST_RES;
                 else if (cnt_i >= DIS_LIM) nxt = ST_DIS;
         ST_DIS: if (lvl_i) nxt = ST_RES;
         ST_RES: if (!lvl_i) nxt = ST_RST;
                 else if (cnt_i >= RES_LIM) nxt = ST_EN;
         default: nxt = ST_DIS;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         st        <= ST_DIS;
         clk_en_o  <= 1'b0;
         rst_act_o <= 1'b0;
         dis_o     <= 1'b1;
         up_o      <= 1'b0;
      end else begin
         st        <= nxt;
         clk_en_o  <= (nxt != ST_DIS);
         rst_act_o <= (nxt == ST_RST);
         dis_o     <= (nxt == ST_DIS);
         up_o      <= (nxt == ST_EN);
      end
   end
endmodule

// File: rtl/link_pwr_gate.sv
module link_pwr_gate #(
   parameter int CTL_W    = 2,
   parameter int DATA_W   = 8,
   parameter int SYNC_STG = 2,
   parameter int RST_CYC  = 250,
   parameter int DIS_CYC  = 3375,
   parameter int RES_CYC  = 2125
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              lps_i,
   input  logic [CTL_W-1:0]  ctl_i,
   input  logic [DATA_W-1:0] data_i,
   output logic [CTL_W-1:0]  ctl_o,
   output logic [DATA_W-1:0] data_o,
   output logic              clk_en_o,
   output logic              rst_act_o,
   output logic              dis_o,
   output logic              up_o
);
   localparam int MAX_CYC = (DIS_CYC > RES_CYC) ? DIS_CYC : RES_CYC;
   localparam int CNT_W   = $clog2(MAX_CYC + 1);

   if (SYNC_STG < 2) begin : g_bad_sync
      $error("SYNC_STG must be at least 2");
   end
   if (RST_CYC < 2 || RST_CYC >= DIS_CYC) begin : g_bad_thr
      $error("RST_CYC must lie between 2 and DIS_CYC-1");
   end
   if (RES_CYC < 2) begin : g_bad_res
      $error("RES_CYC must be at least 2");
   end

   logic             lps_s;
   logic             lvl;
   logic [CNT_W-1:0] cnt;

   lpg_sync #(.STAGES(SYNC_STG)) u_sync (
      .clk (clk),
      .rst (rst),
      .d   (lps_i),
      .q   (lps_s)
   );

   lpg_timer #(.MAX_CYC(MAX_CYC)) u_tmr (
      .clk   (clk),
      .rst   (rst),
      .lvl_i (lps_s),
      .lvl_o (lvl),
      .cnt_o (cnt)
   );

   lpg_fsm #(
      .RST_CYC (RST_CYC),
      .DIS_CYC (DIS_CYC),
      .RES_CYC (RES_CYC),
      .CNT_W   (CNT_W)
   ) u_fsm (
      .clk       (clk),
      .rst       (rst),
      .lvl_i     (lvl),
      .cnt_i     (cnt),
      .clk_en_o  (clk_en_o),
      .rst_act_o (rst_act_o),
      .dis_o     (dis_o),
      .up_o      (up_o)
   );

   assign ctl_o  = ctl_i  & {CTL_W{up_o}};
   assign data_o = data_i & {DATA_W{up_o}};
endmodule

// File: rtl/lpg_chk.sv
module lpg_chk #(
   parameter int CTL_W  = 2,
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst,
   input logic [CTL_W-1:0]  ctl_i,
   input logic [DATA_W-1:0] data_i,
   input logic [CTL_W-1:0]  ctl_o,
   input logic [DATA_W-1:0] data_o,
   input logic              clk_en_o,
   input logic              rst_act_o,
   input logic              dis_o,
   input logic              up_o
);
   // R3
   forced_low_chk: assert property (@(posedge clk) disable iff (rst)
      !up_o |-> (ctl_o == '0 && data_o == '0));

   // R2
   pass_thru_chk: assert property (@(posedge clk) disable iff (rst)
      up_o |-> (ctl_o == ctl_i && data_o == data_i && clk_en_o));

   // R5
   dis_after_rst_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(dis_o) |-> $past(rst_act_o));

   // R8
   flags_onehot_chk: assert property (@(posedge clk) disable iff (rst)
      $onehot0({rst_act_o, dis_o, up_o}));

   // R8
   clk_gate_chk: assert property (@(posedge clk) disable iff (rst)
      clk_en_o == !dis_o);

   // R6
   up_from_restore_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(up_o) |-> $past(clk_en_o && !rst_act_o && !dis_o));
endmodule

bind link_pwr_gate lpg_chk #(.CTL_W(CTL_W), .DATA_W(DATA_W)) u_chk (
   .clk       (clk),
   .rst       (rst),
   .ctl_i     (ctl_i),
   .data_i    (data_i),
   .ctl_o     (ctl_o),
   .data_o    (data_o),
   .clk_en_o  (clk_en_o),
   .rst_act_o (rst_act_o),
   .dis_o     (dis_o),
   .up_o      (up_o)
);

// File: tb/sim_link_pwr_gate.sv
`timescale 1ns/1ps
module sim_link_pwr_gate;
   localparam int RST_CYC = 250;
   localparam int DIS_CYC = 3375;
   localparam int RES_CYC = 2125;
   localparam int MARGIN  = 12;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       lps_i = 1'b0;
   logic [1:0] ctl_i = 2'b00;
   logic [7:0] data_i = 8'h00;
   logic [1:0] ctl_o;
   logic [7:0] data_o;
   logic       clk_en_o, rst_act_o, dis_o, up_o;

   int total = 0;
   int bad   = 0;
   bit done  = 0;

   always #4 clk = ~clk;

   link_pwr_gate #(.RST_CYC(RST_CYC), .DIS_CYC(DIS_CYC), .RES_CYC(RES_CYC)) u0 (
      .clk(clk), .rst(rst), .lps_i(lps_i), .ctl_i(ctl_i), .data_i(data_i),
      .ctl_o(ctl_o), .data_o(data_o), .clk_en_o(clk_en_o),
      .rst_act_o(rst_act_o), .dis_o(dis_o), .up_o(up_o)
   );

   task automatic wait_cyc(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic chk(input string req, input string what, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // state vector {clk_en, rst_act, dis, up}
   function automatic int flags();
      return {28'd0, clk_en_o, rst_act_o, dis_o, up_o};
   endfunction

   task automatic t_reset();
      ctl_i = 2'b11; data_i = 8'hA5;
      wait_cyc(5);
      chk("R1", "flags in reset", flags(), 4'b0010);
      chk("R1", "outputs in reset", {ctl_o, data_o}, 0);
      rst = 1'b0;
      wait_cyc(50);
      chk("R1", "flags after release, lps low", flags(), 4'b0010);
      chk("R1", "outputs after release", {ctl_o, data_o}, 0);
   endtask

   task automatic t_restore_first();
      lps_i = 1'b1;
      wait_cyc(RES_CYC / 2);
      chk("R6", "flags mid restore", flags(), 4'b1000);
      chk("R6", "outputs mid restore", {ctl_o, data_o}, 0);
      wait_cyc(RES_CYC / 2 - 2 * MARGIN);
      chk("R6", "flags just before restore end", flags(), 4'b1000);
      wait_cyc(3 * MARGIN);
      chk("R6", "flags after restore", flags(), 4'b1001);
   endtask

   task automatic t_pass();
      ctl_i = 2'b01; data_i = 8'h3C;
      wait_cyc(1);
      chk("R2", "pass pattern 1", {ctl_o, data_o}, {2'b01, 8'h3C});
      ctl_i = 2'b10; data_i = 8'hC3;
      wait_cyc(1);
      chk("R2", "pass pattern 2", {ctl_o, data_o}, {2'b10, 8'hC3});
      ctl_i = 2'b11; data_i = 8'hFF;
      wait_cyc(1);
      chk("R2", "pass pattern 3", {ctl_o, data_o}, {2'b11, 8'hFF});
   endtask

   task automatic t_short_low();
      lps_i = 1'b0;
      wait_cyc(RST_CYC - 20);
      chk("R3", "short low keeps enabled", flags(), 4'b1001);
      lps_i = 1'b1;
      wait_cyc(20);
      chk("R3", "enabled after short low", flags(), 4'b1001);
   endtask

   task automatic t_restart();
      lps_i = 1'b0;
      wait_cyc(RST_CYC - 60);
      lps_i = 1'b1;
      wait_cyc(20);
      lps_i = 1'b0;
      wait_cyc(RST_CYC - 60);
      chk("R4", "split low does not reset", flags(), 4'b1001);
      lps_i = 1'b1;
      wait_cyc(20);
   endtask

   task automatic t_reset_then_disable();
      lps_i = 1'b0;
      wait_cyc(RST_CYC - MARGIN);
      chk("R3", "before reset threshold", flags(), 4'b1001);
      wait_cyc(3 * MARGIN);
      chk("R3", "reset flags", flags(), 4'b1100);
      chk("R3", "outputs forced in reset", {ctl_o, data_o}, 0);
      wait_cyc(DIS_CYC - RST_CYC - 4 * MARGIN);
      chk("R5", "before disable threshold", flags(), 4'b1100);
      wait_cyc(3 * MARGIN);
      chk("R5", "disabled flags", flags(), 4'b0010);
      chk("R5", "outputs while disabled", {ctl_o, data_o}, 0);
   endtask

   task automatic t_restore();
      lps_i = 1'b1;
      wait_cyc(RES_CYC - MARGIN);
      chk("R6", "still restoring", flags(), 4'b1000);
      wait_cyc(3 * MARGIN);
      chk("R6", "enabled after restore", flags(), 4'b1001);
   endtask

   task automatic t_abort();
      lps_i = 1'b0;
      wait_cyc(RST_CYC + 3 * MARGIN);
      chk("R7", "reset before abort", flags(), 4'b1100);
      lps_i = 1'b1;
      wait_cyc(RES_CYC / 2);
      chk("R7", "restoring before abort", flags(), 4'b1000);
      lps_i = 1'b0;
      wait_cyc(8);
      chk("R7", "back in reset", flags(), 4'b1100);
      wait_cyc(DIS_CYC - 8 - 2 * MARGIN);
      chk("R7", "disable timed from new edge: not yet", flags(), 4'b1100);
      wait_cyc(3 * MARGIN);
      chk("R7", "disabled after new low", flags(), 4'b0010);
   endtask

   initial begin
      for (int i = 0; i < 200000; i++) begin
         @(posedge clk);
         if (done) break;
      end
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=hang expected=completion");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      t_reset();
      t_restore_first();
      t_pass();
      t_short_low();
      t_pass();
      t_restart();
      t_reset_then_disable();
      t_restore();
      t_pass();
      t_abort();
      t_restore();
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule